// File: doc/BRIEF.md
# CPU/DMA Bus Priority Arbiter

This block shares one internal bus between two requesters, the processor core and the DMA engine. A two-bit priority mode, taken from the DMA channel's control register, picks the policy used when both sides want the bus in the same cycle. The processor can always win, the DMA engine can always win, or the two can take turns. One of the four codes is reserved, and the block gives it a defined meaning so that software writing it cannot leave the bus in an unknown state.

Grants are one-hot and come out in the same cycle as the decision. When the bus is idle, a lone request is granted at once. A grant then stays on the winning side until that side raises its done strobe, and the bus is free again on the next cycle. The mode is looked at only when a new decision is made, so changing it during an access leaves the current owner in place. A single-bit turn pointer remembers which side completed an access last. In rotating mode, the side that completed last goes to the back of the line.

Top module: `cpu_dma_arbiter`

## Requirements
- R1: `cpu_gnt` and `dma_gnt` are never both high in the same cycle.
- R2: Mode 2'b00 on an idle bus with both requesting grants the CPU.
- R3: The reserved mode 2'b10 behaves exactly like 2'b00, so the CPU is granted when both request on an idle bus.
- R4: Mode 2'b11 on an idle bus with both requesting grants the DMA.
- R5: In mode 2'b01, when both request on an idle bus, the side that did not complete the most recent access wins. Right after reset, the CPU wins.
- R6: On an idle bus, a lone requester is granted in the same cycle under every mode.
- R7: Once granted, a side keeps its grant on every following cycle, whether or not it is still requesting, up to and including the cycle in which its own done is high. The bus is idle on the cycle after that. A done in the grant cycle makes a one-cycle access.
- R8: A change of mode while a grant is held has no effect on that grant.
- R9: A done strobe from the side that does not hold the grant is ignored: the current grant stays in place.
- R10: After reset, with no requests, both grants are low.
- R11: The turn pointer records completions in every mode. If the last completed access was the CPU's, made under a fixed mode, then the DMA wins the first contested decision in mode 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | CPU requests the bus |
| dma_req | input | 1 | DMA requests the bus |
| cpu_done | input | 1 | CPU access completes this cycle |
| dma_done | input | 1 | DMA access completes this cycle |
| prio_mode | input | MODE_W | Priority mode: 00 CPU first, 01 rotate, 10 reserved (CPU first), 11 DMA first |
| cpu_gnt | output | 1 | Bus granted to CPU |
| dma_gnt | output | 1 | Bus granted to DMA |

## Verification
The bench builds the block with its default parameters: a two-bit mode and the turn pointer starting on the CPU side. With these defaults, all four mode codes can be driven, including the reserved one. The post-reset rotate order can be checked by resetting a second time in the middle of the run. Directed sequences cover held grants, mode changes during a held access, stray done strobes, and a handover from a fixed mode into rotation. A long stretch of pseudo-random requests, done strobes and modes then follows, with every cycle compared against the behavioural model.

// File: rtl/arb_prio_pkg.sv
package arb_prio_pkg;

   typedef enum logic [1:0] {
      POL_CPU_FIRST = 2'd0,
      POL_DMA_FIRST = 2'd1,
      POL_ROTATE    = 2'd2
   } pol_e;

   typedef enum logic [1:0] {
      OWN_NONE = 2'd0,
      OWN_CPU  = 2'd1,
      OWN_DMA  = 2'd2
   } owner_e;

   localparam int CODE_CPU_FIRST = 0;
   localparam int CODE_ROTATE    = 1;
   localparam int CODE_RESERVED  = 2;
   localparam int CODE_DMA_FIRST = 3;

endpackage

// File: rtl/arb_mode_decode.sv
module arb_mode_decode
   import arb_prio_pkg::*;
#(
   parameter int MODE_W = 2
) (
   input  logic [MODE_W-1:0] mode_i,
   output pol_e              pol_o
);

   generate
      if (MODE_W != 2) begin : g_bad_width
         $error("arb_mode_decode: MODE_W must be 2");
      end
   endgenerate

   always_comb begin
      unique case (int'(mode_i))
         CODE_ROTATE:    pol_o = POL_ROTATE;
         CODE_DMA_FIRST: pol_o = POL_DMA_FIRST;
         CODE_RESERVED:  pol_o = POL_CPU_FIRST;
         default:        pol_o = POL_CPU_FIRST;
      endcase
   end

endmodule

// File: rtl/arb_rot_ptr.sv
module arb_rot_ptr #(
   parameter bit RESET_CPU = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_fin,
   input  logic dma_fin,
   output logic cpu_hi_o
);

   localparam logic INIT_VAL = RESET_CPU;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_hi_o <= INIT_VAL;
      end else if (cpu_fin) begin
         cpu_hi_o <= 1'b0;
      end else if (dma_fin) begin
         cpu_hi_o <= 1'b1;
      end
   end

endmodule

// File: rtl/arb_owner.sv
module arb_owner
   import arb_prio_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_pick,
   input  logic dma_pick,
   input  logic cpu_done,
   input  logic dma_done,
   output logic cpu_gnt_o,
   output logic dma_gnt_o,
   output logic held_o
);

   owner_e owner_q;
   owner_e owner_d;

   assign held_o    = (owner_q != OWN_NONE);
   assign cpu_gnt_o = (owner_q == OWN_CPU) || (!held_o && cpu_pick);
   assign dma_gnt_o = (owner_q == OWN_DMA) || (!held_o && dma_pick && !cpu_pick);

   always_comb begin
      owner_d = OWN_NONE;
      if (cpu_gnt_o && !cpu_done) begin
         owner_d = OWN_CPU;
      end else if (dma_gnt_o && !dma_done) begin
         owner_d = OWN_DMA;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= OWN_NONE;
      end else begin
         owner_q <= owner_d;
      end
   end

endmodule

// File: rtl/cpu_dma_arbiter.sv
module cpu_dma_arbiter
   import arb_prio_pkg::*;
#(
   parameter int MODE_W        = 2,
   parameter bit ROT_RESET_CPU = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              dma_req,
   input  logic              cpu_done,
   input  logic              dma_done,
   input  logic [MODE_W-1:0] prio_mode,
   output logic              cpu_gnt,
   output logic              dma_gnt
);

   pol_e pol;
   logic rot_cpu_hi;
   logic cpu_first;
   logic cpu_pick;
   logic dma_pick;
   logic bus_held;
   logic cpu_fin;
   logic dma_fin;

   arb_mode_decode #(.MODE_W(MODE_W)) u_dec (
      .mode_i (prio_mode),
      .pol_o  (pol)
   );

   always_comb begin
      cpu_first = (pol == POL_CPU_FIRST) || ((pol == POL_ROTATE) && rot_cpu_hi);
      cpu_pick  = cpu_req && (!dma_req || cpu_first);
      dma_pick  = dma_req && !cpu_pick;
   end

   arb_owner u_own (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_pick  (cpu_pick),
      .dma_pick  (dma_pick),
      .cpu_done  (cpu_done),
      .dma_done  (dma_done),
      .cpu_gnt_o (cpu_gnt),
      .dma_gnt_o (dma_gnt),
      .held_o    (bus_held)
   );

   assign cpu_fin = cpu_gnt && cpu_done;
   assign dma_fin = dma_gnt && dma_done;

   arb_rot_ptr #(.RESET_CPU(ROT_RESET_CPU)) u_rot (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_fin  (cpu_fin),
      .dma_fin  (dma_fin),
      .cpu_hi_o (rot_cpu_hi)
   );

endmodule

// File: rtl/arb_cpu_dma_chk.sv
module arb_cpu_dma_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_req,
   input logic       dma_req,
   input logic       cpu_done,
   input logic       dma_done,
   input logic [1:0] prio_mode,
   input logic       cpu_gnt,
   input logic       dma_gnt,
   input logic       bus_held
);

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cpu_gnt, dma_gnt})); // R1

   AST_CPU_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_held && cpu_req && dma_req && prio_mode[0] == 1'b0) |-> cpu_gnt); // R2 R3

   AST_DMA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_held && cpu_req && dma_req && prio_mode == 2'b11) |-> dma_gnt); // R4

   AST_ROT_AFTER_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_gnt && cpu_done) |=> (!(cpu_req && dma_req && prio_mode == 2'b01) || dma_gnt)); // R5

   AST_ROT_AFTER_DMA: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_gnt && dma_done) |=> (!(cpu_req && dma_req && prio_mode == 2'b01) || cpu_gnt)); // R5

   AST_LONE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_held && cpu_req && !dma_req) |-> cpu_gnt); // R6

   AST_LONE_DMA: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_held && dma_req && !cpu_req) |-> dma_gnt); // R6

   AST_CPU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_gnt && !cpu_done) |=> cpu_gnt); // R7 R8 R9

   AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_gnt && !dma_done) |=> dma_gnt); // R7 R8 R9

   AST_FREE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ((cpu_gnt && cpu_done) || (dma_gnt && dma_done)) |=> !bus_held); // R7

endmodule

bind cpu_dma_arbiter arb_cpu_dma_chk u_chk (.*);

// File: tb/sim_cpu_dma_arbiter.sv
`timescale 1ns/1ps
module sim_cpu_dma_arbiter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_req = 1'b0;
   logic       dma_req = 1'b0;
   logic       cpu_done = 1'b0;
   logic       dma_done = 1'b0;
   logic [1:0] prio_mode = 2'b00;
   logic       cpu_gnt;
   logic       dma_gnt;

   int checks = 0;
   int failures = 0;

   // behavioural reference state
   int own = 0;          // 0 idle, 1 CPU, 2 DMA
   bit last_was_cpu = 0; // CPU completed most recently
   bit cpu_turn = 1;     // rotate order: CPU first when set

   always #5 clk = ~clk;

   cpu_dma_arbiter u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .dma_req(dma_req),
      .cpu_done(cpu_done), .dma_done(dma_done),
      .prio_mode(prio_mode),
      .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt)
   );

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cpu_req = 0; dma_req = 0; cpu_done = 0; dma_done = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      own = 0;
      cpu_turn = 1;
      last_was_cpu = 0;
   endtask

   task automatic step(input bit cr, input bit dr, input bit cd, input bit dd,
                       input logic [1:0] md, input string req);
      bit ec, ed;
      @(negedge clk);
      cpu_req = cr; dma_req = dr; cpu_done = cd; dma_done = dd; prio_mode = md;
      ec = 0; ed = 0;
      if (own == 1) ec = 1;
      else if (own == 2) ed = 1;
      else if (cr && dr) begin
         if (md == 2'b11) ed = 1;
         else if (md == 2'b01) begin
            if (cpu_turn) ec = 1; else ed = 1;
         end else ec = 1;
      end else begin
         ec = cr;
         ed = dr;
      end
      #1;
      checks++;
      if (cpu_gnt !== ec || dma_gnt !== ed) begin
         failures++;
         $display("FAIL %s: cpu_gnt=%b dma_gnt=%b expected %b %b", req, cpu_gnt, dma_gnt, ec, ed);
      end
      @(posedge clk);
      if (ec && cd) begin cpu_turn = 0; last_was_cpu = 1; end
      else if (ed && dd) begin cpu_turn = 1; last_was_cpu = 0; end
      if (ec && !cd) own = 1;
      else if (ed && !dd) own = 2;
      else own = 0;
   endtask

   initial begin
      #2_000_000;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      do_reset();
      step(0,0,0,0,2'b00,"R10");
      step(0,0,0,0,2'b11,"R10");

      // lone requesters, hold until done
      step(1,0,0,0,2'b11,"R6");
      step(1,1,0,0,2'b11,"R7");
      step(0,1,1,0,2'b11,"R7");
      step(0,1,0,1,2'b11,"R6");
      step(0,0,0,0,2'b00,"R7");

      // fixed modes with contention
      step(1,1,1,0,2'b00,"R2");
      step(1,1,1,0,2'b10,"R3");
      step(1,1,0,1,2'b11,"R4");
      step(1,1,0,0,2'b10,"R3");
      step(1,1,1,0,2'b10,"R3");

      // mode change while held
      step(1,1,0,0,2'b00,"R8");
      step(1,1,0,0,2'b11,"R8");
      step(1,1,0,0,2'b01,"R8");
      step(1,1,1,0,2'b11,"R8");
      step(1,1,0,1,2'b11,"R8");

      // stray done from the idle side
      step(1,0,0,0,2'b00,"R9");
      step(1,1,0,1,2'b00,"R9");
      step(1,1,0,1,2'b11,"R9");
      step(1,1,1,0,2'b00,"R9");

      // pointer carries from fixed mode into rotate
      step(1,0,1,0,2'b00,"R11");
      step(1,1,1,1,2'b01,"R11");

      // rotate right after reset
      do_reset();
      step(1,1,1,1,2'b01,"R5");
      for (int i = 0; i < 6; i++) step(1,1,1,1,2'b01,"R5");
      step(1,1,0,0,2'b01,"R5");
      step(1,1,0,0,2'b01,"R7");
      step(1,1,1,0,2'b01,"R5");
      step(1,1,0,1,2'b01,"R5");

      // mixed pseudo-random traffic
      for (int i = 0; i < 400; i++) begin
         logic [5:0] r;
         r = 6'($urandom);
         step(r[0], r[1], r[2], r[3], r[5:4], "R1");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule